// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between an internal request port and an external 128K x 8 asynchronous static RAM. It takes one single-word read or write at a time and turns it into a sequence of timed strobes on the memory pins. The RAM has a 17-bit address, an 8-bit bidirectional data bus, two chip enables of opposite polarity (one active low, one active high), an active-low write enable and an active-low output enable. The pad is not part of the block. The controller drives a data-out bus and an output-enable pin for the tri-state buffer, and it takes the pad's input data back on a separate bus.

Each memory timing interval, in nanoseconds, comes from a speed-grade parameter chosen at elaboration. The interval is converted to a count of system clocks by rounding up against the clock-period parameter. The chip is deselected between accesses. The address moves only in the idle cycle that separates two accesses. The output enable is held high for the whole of every write, so the turnaround condition between the RAM's own drivers and the controller's drivers cannot arise. Read data is registered at the end of the access and presented for one cycle.

Requests follow valid/ready rules. `req_ready` is high only while the controller is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and the requester must hold the request stable until that edge. The read response has no back-pressure: `rdata_valid` pulses for one cycle and the consumer must take `rdata` in that cycle.

Top module: `sram_async_ctl`

## Requirements
- R1: While reset is held and right after it, the pins are: `sram_ce_n`=1, `sram_ce2`=0, `sram_we_n`=1, `sram_oe_n`=1, `sram_dq_oe`=0, `rdata_valid`=0. `req_ready`=1.
- R2: `req_ready` is 1 only in the idle state. In that state the chip is deselected (`sram_ce_n`=1, `sram_ce2`=0) and the data output enable is 0. At least one such idle cycle separates any two accesses.
- R3: An accepted read makes the chip selected, `sram_oe_n`=0 and `sram_we_n`=1 for RDC cycles, starting at the accepting edge. RDC = max(ceil(tAA/T), ceil(tOE/T)), where T = CLK_NS. At the default grade and T=8, RDC=5.
- R4: The read data is registered from `sram_dq_in` on the edge that ends the RDC-th read cycle. `rdata_valid` is then 1 for exactly one cycle, RDC cycles after the accepting edge, with the stored byte on `rdata`.
- R5: An accepted write runs in three phases. First, one setup cycle with the chip selected and `sram_we_n`=1. Then WRC cycles with `sram_we_n`=0. Then one hold cycle with `sram_we_n`=1 and the chip still selected. WRC = max(ceil(tWP/T), ceil(tDW/T), ceil(tAW/T)-1, ceil(tWC/T)-3, 1). At the default grade and T=8, WRC=4.
- R6: `sram_dq_oe` is 1 from the first cycle with `sram_we_n` low through the one cycle after `sram_we_n` returns high, and 0 at all other times, including every read. `sram_dq_out` carries the write byte whenever `sram_dq_oe` is 1.
- R7: `sram_oe_n` stays 1 in every write cycle.
- R8: `sram_addr` holds the request's address for the whole access. It changes only while the chip is deselected or `sram_we_n` is 1, and never while `sram_we_n` is low.
- R9: SPEED_NS selects the timing grade, with values (tAA, tOE, tWC, tAW, tWP, tDW) in ns. 35 gives 35/25/35/30/25/20. 55 gives 55/30/55/50/45/25. 70 gives 70/35/70/60/55/30. Any other value gives the 35 grade. The write pulse then lasts at least tWP, and the write data is driven for at least tDW before the pulse ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write byte |
| rdata_valid | output | 1 | One-cycle read-data strobe |
| rdata | output | 8 | Read byte |
| sram_addr | output | 17 | Memory address pins |
| sram_ce_n | output | 1 | Active-low chip enable |
| sram_ce2 | output | 1 | Active-high chip enable |
| sram_we_n | output | 1 | Active-low write enable |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_dq_out | output | 8 | Data toward the pad |
| sram_dq_oe | output | 1 | Pad drive enable |
| sram_dq_in | input | 8 | Data from the pad |

## Verification
The bench's memory model shows a junk byte until both the access delay and the output-enable delay, measured in nanoseconds, have passed. A controller that samples one cycle early therefore returns junk, and the read-back compare catches it. The model commits a byte only at the end of a select-and-write-enable overlap, and it measures that pulse and the data setup in real time. A shortened pulse, data driven too late, or an address that moves during the pulse all show up as failures, and so does data released before the hold cycle, because the read-back then fails. Back-to-back requests with `req_valid` held high expose a missing idle cycle as a `req_ready` mismatch. Writes followed by reads at the address extremes and with all-zero and all-one data expose address or data bits that are dropped.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_READ,
    PH_WSETUP,
    PH_WPULSE,
    PH_WHOLD
  } phase_e;

  typedef struct packed {
    int unsigned t_aa;
    int unsigned t_oe;
    int unsigned t_wc;
    int unsigned t_aw;
    int unsigned t_wp;
    int unsigned t_dw;
  } grade_t;

  function automatic grade_t grade_ns(input int unsigned speed);
    grade_t g;
    case (speed)
      55:      g = '{t_aa: 55, t_oe: 30, t_wc: 55, t_aw: 50, t_wp: 45, t_dw: 25};
      70:      g = '{t_aa: 70, t_oe: 35, t_wc: 70, t_aw: 60, t_wp: 55, t_dw: 30};
      default: g = '{t_aa: 35, t_oe: 25, t_wc: 35, t_aw: 30, t_wp: 25, t_dw: 20};
    endcase
    return g;
  endfunction

  function automatic int unsigned cdiv(input int unsigned a, input int unsigned b);
    return (a + b - 1) / b;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned read_cycles(input int unsigned speed, input int unsigned clk_ns);
    grade_t g;
    int unsigned n;
    g = grade_ns(speed);
    n = umax(cdiv(g.t_aa, clk_ns), cdiv(g.t_oe, clk_ns));
    return umax(n, 1);
  endfunction

  // Setup cycle counts toward address-valid-to-end; setup + hold + idle toward write cycle.
  function automatic int unsigned write_cycles(input int unsigned speed, input int unsigned clk_ns);
    grade_t g;
    int unsigned n;
    int unsigned aw;
    int unsigned wc;
    g  = grade_ns(speed);
    n  = umax(cdiv(g.t_wp, clk_ns), cdiv(g.t_dw, clk_ns));
    aw = cdiv(g.t_aw, clk_ns);
    wc = cdiv(g.t_wc, clk_ns);
    if (aw > 1) n = umax(n, aw - 1);
    if (wc > 3) n = umax(n, wc - 3);
    return umax(n, 1);
  endfunction

endpackage

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctl_pkg::*;
#(
  parameter int unsigned RD_CYC = 5,
  parameter int unsigned WR_CYC = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_valid,
  input  logic   req_write,
  output logic   req_ready,
  output logic   accept,
  output logic   cap,
  output phase_e phase_d
);

  localparam int unsigned MAXC = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
  localparam int unsigned CW   = $clog2(MAXC + 1) + 1;

  phase_e        phase_q;
  logic [CW-1:0] cnt_q, cnt_d;

  assign req_ready = (phase_q == PH_IDLE);
  assign accept    = req_ready && req_valid;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    cap     = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (req_valid) begin
          phase_d = req_write ? PH_WSETUP : PH_READ;
          cnt_d   = '0;
        end
      end
      PH_READ: begin
        if (cnt_q == CW'(RD_CYC - 1)) begin
          phase_d = PH_IDLE;
          cap     = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_WSETUP: begin
        phase_d = PH_WPULSE;
        cnt_d   = '0;
      end
      PH_WPULSE: begin
        if (cnt_q == CW'(WR_CYC - 1)) phase_d = PH_WHOLD;
        else                          cnt_d   = cnt_q + 1'b1;
      end
      PH_WHOLD: phase_d = PH_IDLE;
      default:  phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  // R2: after any access the sequencer lands in idle before taking another
  a_r2_idle_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> req_ready);
  a_r2_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

endmodule

// File: rtl/sram_pin_drv.sv
module sram_pin_drv
  import sram_ctl_pkg::*;
#(
  parameter int unsigned AW = 17,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  phase_e        phase_d,
  input  logic          accept,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [AW-1:0] sram_addr,
  output logic          sram_ce_n,
  output logic          sram_ce2,
  output logic          sram_we_n,
  output logic          sram_oe_n,
  output logic [DW-1:0] sram_dq_out,
  output logic          sram_dq_oe
);

  logic sel_d, we_d, rd_d, drive_d;

  assign sel_d   = (phase_d != PH_IDLE);
  assign we_d    = (phase_d == PH_WPULSE);
  assign rd_d    = (phase_d == PH_READ);
  assign drive_d = (phase_d == PH_WPULSE) || (phase_d == PH_WHOLD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sram_addr   <= '0;
      sram_dq_out <= '0;
      sram_ce_n   <= 1'b1;
      sram_ce2    <= 1'b0;
      sram_we_n   <= 1'b1;
      sram_oe_n   <= 1'b1;
      sram_dq_oe  <= 1'b0;
    end else begin
      sram_ce_n  <= !sel_d;
      sram_ce2   <= sel_d;
      sram_we_n  <= !we_d;
      sram_oe_n  <= !rd_d;
      sram_dq_oe <= drive_d;
      if (accept) begin
        sram_addr   <= req_addr;
        sram_dq_out <= req_wdata;
      end
    end
  end

  // R5: write strobe only inside a selected window
  a_r5_we_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (!sram_ce_n && sram_ce2));
  // R7: output enable stays off while writing
  a_r7_oe_off_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> sram_oe_n);
  // R8: address frozen across the write strobe
  a_r8_addr_stable_we: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_we_n && $past(!sram_we_n)) |-> $stable(sram_addr));
  a_r8_addr_move_safe: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sram_addr) |-> (sram_we_n || sram_ce_n || !sram_ce2));
  // R6: pad drive brackets the strobe
  a_r6_drive_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_we_n) |-> sram_dq_oe);
  a_r6_drive_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> sram_dq_oe);
  a_r6_drive_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |=> !sram_dq_oe);
  a_r6_no_drive_read: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> !sram_dq_oe);

endmodule

// File: rtl/sram_rd_cap.sv
module sram_rd_cap #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic [DW-1:0] dq_in,
  output logic          rdata_valid,
  output logic [DW-1:0] rdata
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_valid <= 1'b0;
      rdata       <= '0;
    end else begin
      rdata_valid <= cap;
      if (cap) rdata <= dq_in;
    end
  end

  // R4: response strobe is a single-cycle pulse
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_valid |=> !rdata_valid);

endmodule

// File: rtl/sram_async_ctl.sv
module sram_async_ctl
  import sram_ctl_pkg::*;
#(
  parameter int unsigned SPEED_NS = 35,
  parameter int unsigned CLK_NS   = 8,
  parameter int unsigned AW       = 17,
  parameter int unsigned DW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rdata_valid,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] sram_addr,
  output logic          sram_ce_n,
  output logic          sram_ce2,
  output logic          sram_we_n,
  output logic          sram_oe_n,
  output logic [DW-1:0] sram_dq_out,
  output logic          sram_dq_oe,
  input  logic [DW-1:0] sram_dq_in
);

  localparam int unsigned RD_CYC = read_cycles(SPEED_NS, CLK_NS);
  localparam int unsigned WR_CYC = write_cycles(SPEED_NS, CLK_NS);

  phase_e phase_d;
  logic   accept;
  logic   cap;

  sram_seq #(
    .RD_CYC (RD_CYC),
    .WR_CYC (WR_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_ready (req_ready),
    .accept    (accept),
    .cap       (cap),
    .phase_d   (phase_d)
  );

  sram_pin_drv #(
    .AW (AW),
    .DW (DW)
  ) u_pins (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase_d     (phase_d),
    .accept      (accept),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .sram_addr   (sram_addr),
    .sram_ce_n   (sram_ce_n),
    .sram_ce2    (sram_ce2),
    .sram_we_n   (sram_we_n),
    .sram_oe_n   (sram_oe_n),
    .sram_dq_out (sram_dq_out),
    .sram_dq_oe  (sram_dq_oe)
  );

  sram_rd_cap #(
    .DW (DW)
  ) u_cap (
    .clk         (clk),
    .rst_n       (rst_n),
    .cap         (cap),
    .dq_in       (sram_dq_in),
    .rdata_valid (rdata_valid),
    .rdata       (rdata)
  );

  // R2: ready only while the memory is deselected and undriven
  a_r2_ready_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_ce_n && !sram_ce2 && !sram_dq_oe));
  // R4: response appears only as a read finishes
  a_r4_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_valid |-> $past(!sram_oe_n));

endmodule

// File: tb/sram_async_ctl_tb.sv
`timescale 1ns/1ps
module sram_async_ctl_tb;

  localparam real TCLK = 8.0;
  // grade 35 timing in ns, from the requirements
  localparam int TAA = 35, TOE = 25, TWC = 35, TAW = 30, TWP = 25, TDW = 20;
  localparam int CK  = 8;
  function automatic int mx(input int a, input int b); return a > b ? a : b; endfunction
  localparam int RDC = mx((TAA+CK-1)/CK, (TOE+CK-1)/CK);
  localparam int WRC = mx(mx((TWP+CK-1)/CK, (TDW+CK-1)/CK),
                          mx((TAW+CK-1)/CK - 1, (TWC+CK-1)/CK - 3));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rdata_valid;
  logic [7:0] rdata;
  logic [16:0] sram_addr;
  logic sram_ce_n, sram_ce2, sram_we_n, sram_oe_n, sram_dq_oe;
  logic [7:0] sram_dq_out;
  logic [7:0] sram_dq_in = 8'hEE;

  always #(TCLK/2) clk = ~clk;

  sram_async_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rdata_valid(rdata_valid), .rdata(rdata), .sram_addr(sram_addr),
    .sram_ce_n(sram_ce_n), .sram_ce2(sram_ce2), .sram_we_n(sram_we_n),
    .sram_oe_n(sram_oe_n), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
    .sram_dq_in(sram_dq_in)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] seed(input int a);
    return a[7:0] ^ a[15:8] ^ {7'd0, a[16]} ^ 8'h5A;
  endfunction

  // ---------------- memory device model (ns-level) ----------------
  logic [7:0] phys [int];
  function automatic logic [7:0] pget(input int a);
    return phys.exists(a) ? phys[a] : seed(a);
  endfunction

  real t_acc = 0.0, t_oe = 0.0, t_wr = 0.0, t_dat = 0.0;
  logic p_sel = 1'b0, p_wr = 1'b0, p_oe_n = 1'b1, p_dqoe = 1'b0;
  logic [16:0] p_addr = '0;
  logic [7:0]  p_dq = '0;

  initial begin
    #0.5;
    forever begin
      logic sel, wr;
      real now;
      #1;
      now = $realtime;
      sel = !sram_ce_n && sram_ce2;
      wr  = sel && !sram_we_n;
      if (sram_addr != p_addr) begin
        chk(!(p_wr && wr), "R8 addr moved during write", int'(sram_addr), int'(p_addr));
        t_acc = now;
      end
      if (sel && !p_sel) t_acc = now;
      if (!sram_oe_n && p_oe_n) t_oe = now;
      if ((sram_dq_out != p_dq) || (sram_dq_oe && !p_dqoe)) t_dat = now;
      if (wr && !p_wr) begin
        t_wr = now;
        chk(sram_oe_n, "R7 oe low at write start", int'(sram_oe_n), 1);
      end
      if (!wr && p_wr) begin
        chk(now - t_wr >= TWP, "R9 write pulse ns", int'(now - t_wr), TWP);
        chk(p_dqoe && (now - t_dat >= TDW), "R9 data setup ns", int'(now - t_dat), TDW);
        phys[int'(p_addr)] = p_dq;
      end
      if (sel && !sram_oe_n && sram_we_n && (now - t_acc >= TAA) && (now - t_oe >= TOE))
        sram_dq_in = pget(int'(sram_addr));
      else
        sram_dq_in = 8'hEE;
      p_sel = sel; p_wr = wr; p_oe_n = sram_oe_n; p_dqoe = sram_dq_oe;
      p_addr = sram_addr; p_dq = sram_dq_out;
    end
  end

  // ---------------- cycle reference model ----------------
  logic [7:0] refm [int];
  int cyc = 0;
  int kind = 0, ph = 0;          // 0 idle, 1 read, 2 write
  logic [16:0] cur_a = '0;
  logic [7:0]  cur_d = '0;
  int due_q[$];
  logic [7:0] dat_q[$];

  task automatic step(input logic v, input logic w, input logic [16:0] a,
                      input logic [7:0] d, output bit fired);
    logic [5:0] exp_v, act_v;
    string tag;
    bit ev;
    @(negedge clk);
    cyc++;
    if (kind != 0) begin
      ph++;
      if ((kind == 1 && ph > RDC) || (kind == 2 && ph > WRC + 2)) kind = 0;
    end
    // {ce_n, ce2, we_n, oe_n, dq_oe, ready}
    if (kind == 0)              begin exp_v = 6'b101101; tag = "R2 idle pins"; end
    else if (kind == 1)         begin exp_v = 6'b011000; tag = "R3 read pins"; end
    else if (ph == 1)           begin exp_v = 6'b011100; tag = "R5 write setup"; end
    else if (ph <= WRC + 1)     begin exp_v = 6'b010110; tag = "R5 write pulse"; end
    else                        begin exp_v = 6'b011110; tag = "R6 write hold"; end
    act_v = {sram_ce_n, sram_ce2, sram_we_n, sram_oe_n, sram_dq_oe, req_ready};
    chk(act_v == exp_v, tag, int'(act_v), int'(exp_v));
    if (kind != 0) chk(sram_addr == cur_a, "R8 address held", int'(sram_addr), int'(cur_a));
    if (sram_dq_oe) chk(sram_dq_out == cur_d, "R6 drive data", int'(sram_dq_out), int'(cur_d));
    ev = (due_q.size() != 0) && (due_q[0] == cyc);
    chk(rdata_valid == ev, "R4 rdata_valid timing", int'(rdata_valid), int'(ev));
    if (ev) begin
      chk(rdata == dat_q[0], "R4 read data", int'(rdata), int'(dat_q[0]));
      void'(due_q.pop_front());
      void'(dat_q.pop_front());
    end
    req_valid = v; req_write = w; req_addr = a; req_wdata = d;
    fired = v && req_ready;
    if (fired) begin
      kind = w ? 2 : 1; ph = 0; cur_a = a; cur_d = d;
      if (w) refm[int'(a)] = d;
      else begin
        due_q.push_back(cyc + RDC + 1);
        dat_q.push_back(refm.exists(int'(a)) ? refm[int'(a)] : seed(int'(a)));
      end
    end
  endtask

  task automatic op(input logic w, input logic [16:0] a, input logic [7:0] d);
    bit f = 1'b0;
    while (!f) step(1'b1, w, a, d, f);
  endtask

  task automatic idle(input int n);
    bit f;
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 17'h0, 8'h0, f);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    logic [31:0] x;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk({sram_ce_n, sram_ce2, sram_we_n, sram_oe_n, sram_dq_oe} == 5'b10110,
        "R1 reset pins", int'({sram_ce_n, sram_ce2, sram_we_n, sram_oe_n, sram_dq_oe}), 'h16);
    chk(!rdata_valid && req_ready, "R1 reset port", int'({rdata_valid, req_ready}), 1);
    rst_n = 1'b1;
    idle(2);
    // boundaries and data extremes: R5 R6 R8 then R3 R4 read-back
    op(1'b1, 17'h00000, 8'hFF);
    op(1'b1, 17'h1FFFF, 8'h00);
    op(1'b1, 17'h0AAAA, 8'hA5);
    op(1'b0, 17'h00000, 8'h0);
    op(1'b0, 17'h1FFFF, 8'h0);
    op(1'b0, 17'h0AAAA, 8'h0);
    op(1'b0, 17'h15555, 8'h0);   // never written: seed pattern
    idle(8);
    // write then read same address back to back
    op(1'b1, 17'h00123, 8'h3C);
    op(1'b0, 17'h00123, 8'h0);
    idle(RDC + 3);
    // mixed traffic with random gaps
    x = 32'h1234_5678;
    for (int i = 0; i < 400; i++) begin
      logic [16:0] a;
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      a = x[20] ? {11'h0, x[5:0]} : (x[21] ? 17'h1FFFF - {11'h0, x[5:0]} : x[16:0]);
      op(x[24], a, x[31:24]);
      if (x[27:26] == 2'b00) idle(int'(x[29:28]));
    end
    idle(RDC + 4);
    chk(due_q.size() == 0, "R4 all reads answered", due_q.size(), 0);
    finish_run();
  end

  initial begin
    #(TCLK * 150000);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

endmodule